// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the current time and date in seven byte-wide BCD registers: seconds, minutes, hours, day of month, month, day of week and a two-digit year. A one-cycle `tick` pulse, produced elsewhere once per second, advances the count. Each step ripples through the registers in the usual way: seconds into minutes, minutes into hours, then into the date, the month and the year. The day of week steps with the date.

Each register can be loaded in parallel from a shared data byte under its own strobe, for example by a register bank decoding a serial command. The top bit of the seconds byte is a run/stop flag. The top bit of the hours byte selects 12-hour form, in which bit 5 marks the afternoon, or 24-hour form, in which bit 5 is the tens-of-hours bit for 20 to 23. All seven registers are always visible on read-back outputs.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the outputs read seconds 8'h00 (running), minutes 8'h00, hours 8'h00 (24-hour form), date 8'h01, month 8'h01, day of week 8'h01 and year 8'h00.
- R2: While seconds bit 7 is 1, ticks change no register. Loading seconds with bit 7 = 0 lets the next tick count again.
- R3: Seconds and minutes count 00 to 59 in BCD (bits 6:4 tens, 3:0 units). Seconds 59 wraps to 00 and advances minutes, and minutes 59 wraps to 00 and carries into the hours.
- R4: In 24-hour form (hours bit 7 = 0, bits 5:4 tens, 3:0 units), hours run 00 to 23. Stepping past 23 gives 00 and starts a new day.
- R5: In 12-hour form (hours bit 7 = 1, bit 5 = PM, bit 4 tens, 3:0 units), hours run 12, 01, ..., 11. Stepping from 11 gives 12 and flips bit 5, and the step out of 11 PM starts a new day. A tick never changes bit 7.
- R6: A new day advances the date from 01 up to the month's length (31 days for months 01, 03, 05, 07, 08, 10, 12 and 30 days for 04, 06, 09, 11), then wraps to 01 and advances the month.
- R7: February has 29 days when the BCD year is divisible by 4 and 28 days otherwise.
- R8: Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R9: Day of week steps 1 to 7 and then back to 1 with each new day.
- R10: A strobe `ld_*` writes `wr_data` to its register, visible on the next cycle. Stored bits: seconds 7:0, minutes 6:0, hours 7 and 5:0 (bit 6 reads 0), date 5:0, month 4:0, day of week 2:0, year 7:0. Any strobe drops the tick of that cycle for every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance pulse |
| wr_data | input | 8 | Load data shared by all strobes |
| ld_sec | input | 1 | Load seconds (bit 7 = halt) |
| ld_min | input | 1 | Load minutes |
| ld_hour | input | 1 | Load hours (bit 7 = 12-hour form) |
| ld_date | input | 1 | Load day of month |
| ld_mon | input | 1 | Load month |
| ld_dow | input | 1 | Load day of week |
| ld_year | input | 1 | Load year |
| sec_q | output | 8 | Seconds read-back |
| min_q | output | 8 | Minutes read-back |
| hour_q | output | 8 | Hours read-back |
| date_q | output | 8 | Date read-back |
| mon_q | output | 8 | Month read-back |
| dow_q | output | 8 | Day of week read-back |
| year_q | output | 8 | Year read-back |

## Verification
Every register is a port, so a wrong carry or wrap decision shows on the cycle after the tick that triggers it. For example, a wrong month length shows as a date of 31 or 32 where 01 was expected, and a missed PM flip shows as a wrong hours byte. Errors in the carry chain only show at rare boundaries, so the stimulus loads values a few seconds before each boundary: end of minute, end of hour, end of day in both hour forms, end of month, leap February and end of century. The stimulus also puts strobes and ticks in the same cycle.

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] wr_data,
  input  logic       ld_sec,
  input  logic       ld_min,
  input  logic       ld_hour,
  input  logic       ld_date,
  input  logic       ld_mon,
  input  logic       ld_dow,
  input  logic       ld_year,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] date_q,
  output logic [7:0] mon_q,
  output logic [7:0] dow_q,
  output logic [7:0] year_q
);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic any_ld, adv;
  logic sec_wrap, min_wrap, hr_carry, day_carry;
  logic is_12h, is_pm, leap;
  logic [1:0] yr_mod4;
  logic [7:0] date_max, hour_nx;

  assign any_ld   = |{ld_sec, ld_min, ld_hour, ld_date, ld_mon, ld_dow, ld_year};
  assign adv      = tick & ~sec_q[7] & ~any_ld;
  assign sec_wrap = sec_q[6:0] == 7'h59;
  assign min_wrap = min_q[6:0] == 7'h59;
  assign hr_carry = sec_wrap & min_wrap;
  assign is_12h   = hour_q[7];
  assign is_pm    = hour_q[5];

  assign day_carry = hr_carry & (is_12h ? (hour_q[4:0] == 5'h11 && is_pm)
                                        : (hour_q[5:0] == 6'h23));

  always_comb begin
    if (is_12h) begin
      if (hour_q[4:0] == 5'h12)      hour_nx = {1'b1, 1'b0, is_pm, 5'h01};
      else if (hour_q[4:0] == 5'h11) hour_nx = {1'b1, 1'b0, ~is_pm, 5'h12};
      else                           hour_nx = {1'b1, 1'b0, is_pm, bcd_inc({3'd0, hour_q[4:0]})[4:0]};
    end else begin
      hour_nx = (hour_q[5:0] == 6'h23) ? 8'h00 : bcd_inc({2'd0, hour_q[5:0]});
    end
  end

  assign yr_mod4 = {year_q[4], 1'b0} + year_q[1:0];
  assign leap    = yr_mod4 == 2'd0;

  always_comb begin
    case (mon_q)
      8'h02:                    date_max = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: date_max = 8'h30;
      default:                  date_max = 8'h31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      dow_q  <= 8'h01;
      year_q <= 8'h00;
    end else if (any_ld) begin
      if (ld_sec)  sec_q  <= wr_data;
      if (ld_min)  min_q  <= {1'b0, wr_data[6:0]};
      if (ld_hour) hour_q <= {wr_data[7], 1'b0, wr_data[5:0]};
      if (ld_date) date_q <= {2'b00, wr_data[5:0]};
      if (ld_mon)  mon_q  <= {3'b000, wr_data[4:0]};
      if (ld_dow)  dow_q  <= {5'b00000, wr_data[2:0]};
      if (ld_year) year_q <= wr_data;
    end else if (adv) begin
      sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
      if (sec_wrap) min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);
      if (hr_carry) hour_q <= hour_nx;
      if (day_carry) begin
        dow_q <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
        if (date_q == date_max) begin
          date_q <= 8'h01;
          if (mon_q == 8'h12) begin
            mon_q  <= 8'h01;
            year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
          end else begin
            mon_q <= bcd_inc(mon_q);
          end
        end else begin
          date_q <= bcd_inc(date_q);
        end
      end
    end
  end

  p_halt_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[7] && !any_ld) |=> $stable({sec_q, min_q, hour_q, date_q, mon_q, dow_q, year_q}));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_ld && sec_q == 8'h59) |=> (sec_q == 8'h00 && min_q != $past(min_q)));

  p_hour_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && hr_carry && hour_q == 8'h23) |=> (hour_q == 8'h00 && dow_q != $past(dow_q)));

  p_mode_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ld |=> hour_q[7] == $past(hour_q[7]));

  p_dow_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_ld && dow_q >= 8'h01 && dow_q <= 8'h07) |=> (dow_q >= 8'h01 && dow_q <= 8'h07));

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sec |=> sec_q == $past(wr_data));

  p_tick_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ld && !ld_sec) |=> $stable(sec_q));

endmodule

// File: tb/rtc_bcd_calendar_tb.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [6:0] ld = 7'd0;
  logic [7:0] sec_q, min_q, hour_q, date_q, mon_q, dow_q, year_q;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] m [7];

  always #2.5 clk = ~clk;

  rtc_bcd_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_data(wr_data),
    .ld_sec(ld[0]), .ld_min(ld[1]), .ld_hour(ld[2]), .ld_date(ld[3]),
    .ld_mon(ld[4]), .ld_dow(ld[5]), .ld_year(ld[6]),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .date_q(date_q),
    .mon_q(mon_q), .dow_q(dow_q), .year_q(year_q));

  function automatic int bin(input logic [7:0] v); return v[7:4] * 10 + v[3:0]; endfunction
  function automatic logic [7:0] bcd(input int n);
    logic [3:0] hi, lo;
    hi = 4'(n / 10); lo = 4'(n % 10);
    return {hi, lo};
  endfunction
  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    int s, mi, h, d, mo, y, w;
    bit pm, c, day;
    if (m[0][7]) return;
    s = bin({1'b0, m[0][6:0]}); mi = bin(m[1]); d = bin(m[3]); mo = bin(m[4]);
    y = bin(m[6]); w = m[5];
    c = 0; day = 0;
    if (s == 59) begin s = 0; c = mi == 59; mi = (mi == 59) ? 0 : mi + 1; end
    else s = s + 1;
    if (c) begin
      if (m[2][7]) begin
        h = bin({3'd0, m[2][4:0]}); pm = m[2][5];
        if (h == 11) begin h = 12; day = pm; pm = ~pm; end
        else if (h == 12) h = 1;
        else h = h + 1;
        m[2] = {1'b1, 1'b0, pm, bcd(h)[4:0]};
      end else begin
        h = bin({2'd0, m[2][5:0]});
        if (h == 23) begin h = 0; day = 1; end else h = h + 1;
        m[2] = bcd(h);
      end
    end
    if (day) begin
      w = (w == 7) ? 1 : w + 1;
      if (d == days_in(mo, y)) begin
        d = 1;
        if (mo == 12) begin mo = 1; y = (y + 1) % 100; end else mo = mo + 1;
      end else d = d + 1;
    end
    m[0] = bcd(s); m[1] = bcd(mi); m[3] = bcd(d); m[4] = bcd(mo); m[5] = 8'(w); m[6] = bcd(y);
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R3", "sec", sec_q, m[0]);
    chk("R3", "min", min_q, m[1]);
    chk(m[2][7] ? "R5" : "R4", "hour", hour_q, m[2]);
    chk("R6", "date", date_q, m[3]);
    chk("R8", "month", mon_q, m[4]);
    chk("R9", "dow", dow_q, m[5]);
    chk("R8", "year", year_q, m[6]);
  endtask

  // one cycle: drive at negedge, model the posedge, compare at next negedge
  task automatic step(input bit t, input logic [6:0] l, input logic [7:0] d);
    tick = t; ld = l; wr_data = d;
    if (l != 0) begin
      if (l[0]) m[0] = d;
      if (l[1]) m[1] = {1'b0, d[6:0]};
      if (l[2]) m[2] = {d[7], 1'b0, d[5:0]};
      if (l[3]) m[3] = {2'b0, d[5:0]};
      if (l[4]) m[4] = {3'b0, d[4:0]};
      if (l[5]) m[5] = {5'b0, d[2:0]};
      if (l[6]) m[6] = d;
    end else if (t) model_tick();
    @(negedge clk);
    tick = 0; ld = 0;
    cmp_all();
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, d, mo, w, y);
    step(0, 7'h01, s); step(0, 7'h02, mi); step(0, 7'h04, h); step(0, 7'h08, d);
    step(0, 7'h10, mo); step(0, 7'h20, w); step(0, 7'h40, y);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01; m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00;
    @(negedge clk);
    chk("R1", "reset sec", sec_q, 8'h00); chk("R1", "reset hour", hour_q, 8'h00);
    chk("R1", "reset date", date_q, 8'h01); chk("R1", "reset month", mon_q, 8'h01);
    chk("R1", "reset dow", dow_q, 8'h01); chk("R1", "reset year", year_q, 8'h00);

    // R10: load beats tick; strobe on another register drops the tick
    step(1, 7'h01, 8'h42); chk("R10", "sec load over tick", sec_q, 8'h42);
    step(1, 7'h02, 8'h17); chk("R10", "tick dropped", sec_q, 8'h42);
    step(0, 7'h04, 8'hFF); chk("R10", "hour bit6 masked", hour_q, 8'hBF);

    // R7: leap and non-leap February
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h24);
    step(1, 0, 0); chk("R7", "leap feb 29", date_q, 8'h29);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h23);
    step(1, 0, 0); chk("R7", "feb 28 -> mar", mon_q, 8'h03); chk("R7", "date 01", date_q, 8'h01);

    // R6: 30-day month
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h07, 8'h10);
    step(1, 0, 0); chk("R6", "apr 30 -> may", mon_q, 8'h05); chk("R9", "dow 7 -> 1", dow_q, 8'h01);

    // R5: 12-hour transitions
    set_time(8'h59, 8'h59, 8'hB1, 8'h10, 8'h06, 8'h02, 8'h05);
    step(1, 0, 0); chk("R5", "11PM -> 12AM", hour_q, 8'h92); chk("R5", "new day", date_q, 8'h11);
    set_time(8'h59, 8'h59, 8'h91, 8'h10, 8'h06, 8'h02, 8'h05);
    step(1, 0, 0); chk("R5", "11AM -> 12PM", hour_q, 8'hB2); chk("R5", "same day", date_q, 8'h10);
    set_time(8'h59, 8'h59, 8'h92, 8'h10, 8'h06, 8'h02, 8'h05);
    step(1, 0, 0); chk("R5", "12 -> 01", hour_q, 8'h81);

    // R8: century end; R4 hour wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h04, 8'h99);
    step(1, 0, 0); chk("R8", "year 99 -> 00", year_q, 8'h00); chk("R4", "23 -> 00", hour_q, 8'h00);
    chk("R8", "month -> 01", mon_q, 8'h01);

    // R2: halt
    step(0, 7'h01, 8'h85);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    chk("R2", "halted sec", sec_q, 8'h85);
    step(0, 7'h01, 8'h05); step(1, 0, 0); chk("R2", "resumed sec", sec_q, 8'h06);

    // random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6000; i++) begin
      int r, sel, v;
      logic [7:0] d;
      r = $urandom % 100;
      if (r < 12) begin
        sel = $urandom % 7;
        case (sel)
          0: d = ($urandom % 25 == 0) ? {1'b1, bcd($urandom % 60)[6:0]} : bcd(50 + $urandom % 10);
          1: d = bcd(55 + $urandom % 5);
          2: if ($urandom % 2) begin
               v = 1 + $urandom % 12;
               d = {1'b1, 1'b0, 1'($urandom % 2), bcd(v)[4:0]};
             end else d = bcd(20 + $urandom % 4);
          3: d = bcd(days_in(bin(m[4]), bin(m[6])) - $urandom % 3);
          4: d = bcd(1 + $urandom % 12);
          5: d = 8'(1 + $urandom % 7);
          default: d = bcd(($urandom % 2) ? 99 : $urandom % 100);
        endcase
        step(($urandom % 2) == 1, 7'(1 << sel), d);
      end else begin
        step(r < 85, 0, 0);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule